// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block is the control sequencer at the front of a small 8-bit processor core. It walks a 16-bit program counter through byte-wide memory and reads each instruction one byte per bus cycle. The first byte of an instruction is the opcode. The decoder uses the opcode to decide whether the instruction is one byte or three bytes long. For a three-byte instruction, the two operand bytes are collected into two temporary registers.

Two three-byte operations use those operands:
- The direct store drives the temporary registers out as a 16-bit address and writes the accumulator value there in one write cycle.
- The jump reloads the program counter from the temporary registers.

Every other opcode is treated as a one-byte no-operation. A ready input lets slow memory stretch any bus cycle.

Top module: `ifetch_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the block presents an opcode fetch from address 0000h: `mem_addr`=0000h, `rd_n`=0, `wr_n`=1, `bus_status`=110.
- R2: With ready high, each byte read takes exactly one clock, and the next read address is the previous read address plus one. This holds after every opcode and after every operand byte.
- R3: Only the opcodes 32h and C3h are three bytes long. Any other opcode, including 00h and 76h, is followed directly by an opcode fetch at the next address.
- R4: The two operand bytes are read in separate cycles with `rd_n`=0, `wr_n`=1 and `bus_status`=010. The address is the program counter.
- R5: After the third byte of opcode 32h, exactly one write cycle follows. In it, `mem_addr` = {byte 3, byte 2}, `mem_wdata` is the `acc` value sampled at the clock edge that accepted byte 3, `wr_n`=0, `rd_n`=1 and `bus_status`=001. The next opcode fetch is at the address just after byte 3.
- R6: After the third byte of opcode C3h, there is no write cycle. The next opcode fetch is at {byte 3, byte 2}, and byte 2 is the low half.
- R7: While `ready` is low, all bus outputs hold their values and the sequence does not advance. A cycle completes at the first clock edge that sees `ready` high.
- R8: `rd_n` and `wr_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ready | input | 1 | High when memory completes the current bus cycle |
| acc | input | 8 | Accumulator value to be stored |
| mem_rdata | input | 8 | Read data from memory |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Write data to memory |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_status | output | 3 | Cycle type: 110 opcode fetch, 010 memory read, 001 memory write |

## Verification
The hardest situation to reach is a wait state that falls inside the store sequence while the accumulator is changing. The write must keep its address and its captured data steady across the stretch. The stimulus runs a store with ready held low on the opcode fetch, on an operand read and on the write cycle. It changes `acc` during the stretched write, and every cycle is compared field by field. A separate case checks that a jump leaves the straight-line address order and runs no write cycle.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  typedef enum logic [1:0] {
    ST_OPC,
    ST_OP2,
    ST_OP3,
    ST_WR
  } seq_st_t;

  typedef enum logic [1:0] {
    K_NOP,
    K_STA,
    K_JMP
  } op_kind_t;
endpackage

// File: rtl/ifs_decode.sv
module ifs_decode
  import ifs_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] OPC_STA = 8'h32,
  parameter logic [DW-1:0] OPC_JMP = 8'hC3
) (
  input  logic [DW-1:0] opc,
  output op_kind_t      kind,
  output logic          multi
);
  always_comb begin
    if (opc == OPC_STA)      kind = K_STA;
    else if (opc == OPC_JMP) kind = K_JMP;
    else                     kind = K_NOP;
    multi = (kind != K_NOP);
  end
endmodule

// File: rtl/ifs_pc.sv
module ifs_pc #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_inc,
  input  logic          en_load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst)          pc <= '0;
    else if (en_load) pc <= load_val;
    else if (en_inc)  pc <= pc + AW'(1);
  end
endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
  import ifs_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] OPC_STA  = 8'h32,
  parameter logic [DW-1:0] OPC_JMP  = 8'hC3,
  parameter logic [2:0]    STS_FETCH = 3'b110,
  parameter logic [2:0]    STS_READ  = 3'b010,
  parameter logic [2:0]    STS_WRITE = 3'b001,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ready,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rd_n,
  output logic          wr_n,
  output logic [2:0]    bus_status
);
  seq_st_t       st, st_n;
  logic [DW-1:0] ir, w_q, x_q, acc_q;
  logic [DW-1:0] dec_in;
  op_kind_t      kind;
  logic          multi;
  logic          pc_inc, pc_load;
  logic [AW-1:0] pc;

  // Opcode comes straight off the bus in the fetch cycle, from IR later.
  assign dec_in = (st == ST_OPC) ? mem_rdata : ir;

  ifs_decode #(.DW(DW), .OPC_STA(OPC_STA), .OPC_JMP(OPC_JMP)) u_dec (
    .opc   (dec_in),
    .kind  (kind),
    .multi (multi)
  );

  ifs_pc #(.AW(AW)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .en_inc   (pc_inc),
    .en_load  (pc_load),
    .load_val ({mem_rdata, w_q}),
    .pc       (pc)
  );

  always_comb begin
    st_n    = st;
    pc_inc  = 1'b0;
    pc_load = 1'b0;
    if (ready) begin
      unique case (st)
        ST_OPC: begin
          pc_inc = 1'b1;
          st_n   = multi ? ST_OP2 : ST_OPC;
        end
        ST_OP2: begin
          pc_inc = 1'b1;
          st_n   = ST_OP3;
        end
        ST_OP3: begin
          if (kind == K_JMP) begin
            pc_load = 1'b1;
            st_n    = ST_OPC;
          end else begin
            pc_inc = 1'b1;
            st_n   = ST_WR;
          end
        end
        ST_WR: st_n = ST_OPC;
        default: st_n = ST_OPC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_OPC;
      ir    <= '0;
      w_q   <= '0;
      x_q   <= '0;
      acc_q <= '0;
    end else begin
      st <= st_n;
      if (ready) begin
        if (st == ST_OPC) ir <= mem_rdata;
        if (st == ST_OP2) w_q <= mem_rdata;
        if (st == ST_OP3) begin
          x_q   <= mem_rdata;
          acc_q <= acc;
        end
      end
    end
  end

  // Bus outputs depend only on registers, never on ready or read data.
  always_comb begin
    mem_addr   = pc;
    mem_wdata  = acc_q;
    rd_n       = 1'b0;
    wr_n       = 1'b1;
    bus_status = STS_READ;
    unique case (st)
      ST_OPC: bus_status = STS_FETCH;
      ST_WR: begin
        mem_addr   = {x_q, w_q};
        rd_n       = 1'b1;
        wr_n       = 1'b0;
        bus_status = STS_WRITE;
      end
      default: bus_status = STS_READ;
    endcase
  end
endmodule

// File: rtl/ifetch_seq_chk.sv
module ifetch_seq_chk #(
  parameter int AW = 16,
  parameter logic [2:0] STS_FETCH = 3'b110,
  parameter logic [2:0] STS_READ  = 3'b010
) (
  input logic          clk,
  input logic          rst,
  input logic          ready,
  input logic [AW-1:0] mem_addr,
  input logic          rd_n,
  input logic          wr_n,
  input logic [2:0]    bus_status
);
  a_r1_reset_fetch: assert property (@(posedge clk)
    rst |=> (mem_addr == '0 && !rd_n && wr_n && bus_status == STS_FETCH));

  a_r2_opcode_step: assert property (@(posedge clk) disable iff (rst)
    (ready && !rd_n && bus_status == STS_FETCH) |=> (mem_addr == $past(mem_addr) + AW'(1)));

  a_r4_read_strobes: assert property (@(posedge clk) disable iff (rst)
    (bus_status == STS_READ) |-> (!rd_n && wr_n));

  a_r5_write_single: assert property (@(posedge clk) disable iff (rst)
    (ready && !wr_n) |=> (!rd_n && wr_n && bus_status == STS_FETCH));

  a_r7_wait_hold: assert property (@(posedge clk) disable iff (rst)
    !ready |=> ($stable(mem_addr) && $stable(rd_n) && $stable(wr_n) && $stable(bus_status)));

  a_r8_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    (rd_n || wr_n));
endmodule

bind ifetch_seq ifetch_seq_chk #(
  .AW(AW), .STS_FETCH(STS_FETCH), .STS_READ(STS_READ)
) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .mem_addr(mem_addr),
  .rd_n(rd_n), .wr_n(wr_n), .bus_status(bus_status)
);

// File: tb/tb_ifetch_seq.sv
module tb_ifetch_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ready = 1'b1;
  logic [7:0]  acc = 8'h00;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        rd_n, wr_n;
  logic [2:0]  bus_status;
  logic [7:0]  rom [256];
  int checks = 0;
  int errors = 0;

  localparam logic [2:0] FET = 3'b110, RDC = 3'b010, WRC = 3'b001;

  always #5 clk = ~clk;

  assign mem_rdata = rom[mem_addr[7:0]];

  ifetch_seq dut (
    .clk(clk), .rst(rst), .ready(ready), .acc(acc), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_n(rd_n), .wr_n(wr_n),
    .bus_status(bus_status)
  );

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) rom[i] = 8'h00;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ready = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Check the cycle now on the bus, set ready for the coming edge, advance.
  task automatic cyc(string tag, logic rdy, logic [15:0] ea, logic erd,
                     logic ewr, logic [2:0] est, logic [7:0] ewd);
    logic bad;
    checks++;
    bad = (mem_addr !== ea) || (rd_n !== erd) || (wr_n !== ewr) ||
          (bus_status !== est) || (!ewr && mem_wdata !== ewd);
    if (bad) begin
      errors++;
      $display("FAIL %s: addr=%h rd_n=%b wr_n=%b st=%b wd=%h expected addr=%h rd_n=%b wr_n=%b st=%b wd=%h",
               tag, mem_addr, rd_n, wr_n, bus_status, mem_wdata, ea, erd, ewr, est, ewd);
    end
    ready = rdy;
    @(negedge clk);
  endtask

  task automatic t_reset();
    clear_rom();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cyc("R1 in reset", 1'b1, 16'h0000, 1'b0, 1'b1, FET, 8'h00);
    rst = 1'b0;
    cyc("R1 after reset", 1'b1, 16'h0000, 1'b0, 1'b1, FET, 8'h00);
  endtask

  task automatic t_nops();
    clear_rom();
    rom[1] = 8'h76;
    rom[2] = 8'hFF;
    do_reset();
    cyc("R2 fetch 0", 1'b1, 16'h0000, 1'b0, 1'b1, FET, 8'h00);
    cyc("R3 fetch 1", 1'b1, 16'h0001, 1'b0, 1'b1, FET, 8'h00);
    cyc("R3 fetch 2", 1'b1, 16'h0002, 1'b0, 1'b1, FET, 8'h00);
    cyc("R2 fetch 3", 1'b1, 16'h0003, 1'b0, 1'b1, FET, 8'h00);
    cyc("R2 fetch 4", 1'b1, 16'h0004, 1'b0, 1'b1, FET, 8'h00);
  endtask

  task automatic t_store();
    clear_rom();
    rom[0] = 8'h32; rom[1] = 8'h34; rom[2] = 8'h12;
    acc = 8'hA5;
    do_reset();
    cyc("R1 opcode", 1'b1, 16'h0000, 1'b0, 1'b1, FET, 8'h00);
    cyc("R4 byte2", 1'b1, 16'h0001, 1'b0, 1'b1, RDC, 8'h00);
    cyc("R4 byte3", 1'b1, 16'h0002, 1'b0, 1'b1, RDC, 8'h00);
    cyc("R5 write", 1'b1, 16'h1234, 1'b1, 1'b0, WRC, 8'hA5);
    cyc("R5 next fetch", 1'b1, 16'h0003, 1'b0, 1'b1, FET, 8'h00);
  endtask

  task automatic t_jump();
    clear_rom();
    rom[0] = 8'hC3; rom[1] = 8'h40; rom[2] = 8'h00;
    do_reset();
    cyc("R3 jump opcode", 1'b1, 16'h0000, 1'b0, 1'b1, FET, 8'h00);
    cyc("R4 jump lo", 1'b1, 16'h0001, 1'b0, 1'b1, RDC, 8'h00);
    cyc("R4 jump hi", 1'b1, 16'h0002, 1'b0, 1'b1, RDC, 8'h00);
    cyc("R6 target", 1'b1, 16'h0040, 1'b0, 1'b1, FET, 8'h00);
    cyc("R6 after target", 1'b1, 16'h0041, 1'b0, 1'b1, FET, 8'h00);
  endtask

  task automatic t_wait();
    clear_rom();
    rom[0] = 8'h32; rom[1] = 8'hEF; rom[2] = 8'hBE;
    acc = 8'h3C;
    do_reset();
    ready = 1'b0;
    cyc("R7 hold fetch a", 1'b0, 16'h0000, 1'b0, 1'b1, FET, 8'h00);
    cyc("R7 hold fetch b", 1'b1, 16'h0000, 1'b0, 1'b1, FET, 8'h00);
    cyc("R7 fetch done", 1'b0, 16'h0001, 1'b0, 1'b1, RDC, 8'h00);
    cyc("R7 hold byte2", 1'b1, 16'h0001, 1'b0, 1'b1, RDC, 8'h00);
    cyc("R4 byte3 waited", 1'b1, 16'h0002, 1'b0, 1'b1, RDC, 8'h00);
    acc = 8'hFF;
    cyc("R5 write stretched", 1'b0, 16'hBEEF, 1'b1, 1'b0, WRC, 8'h3C);
    cyc("R7 write held", 1'b1, 16'hBEEF, 1'b1, 1'b0, WRC, 8'h3C);
    cyc("R8 back to fetch", 1'b1, 16'h0003, 1'b0, 1'b1, FET, 8'h00);
  endtask

  initial begin
    t_reset();
    t_nops();
    t_store();
    t_jump();
    t_wait();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: R7 sequence hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule